// File: doc/BRIEF.md
# Configurable Logic Cell

A single programmable cell intended to be tiled many times inside an embedded programmable-logic fabric. Its function comes from a three-input lookup table. An eight-bit truth table is held in configuration flip-flops, and the three user inputs select one of those bits. The selected bit either drives the output directly or passes through an output flip-flop.

Configuration bits set four things. They choose whether the output is registered. They enable synchronous set and synchronous reset on the output register, each on its own. They also choose whether that register captures on the rising or the falling clock edge. All twelve configuration bits sit in ordinary flip-flops that form a serial shift chain. A chain output lets any number of cells be loaded in series from one configuration stream.

In use, the configuration stream is shifted in with `cfg_shift_en` held high, one bit per `cfg_clk` rising edge. The shift enable is then dropped and the cell behaves as the configured logic function.

Top module: `cle_cell`

## Requirements
- R1: A high `rst` at a rising edge clears all twelve configuration bits and the output register. After reset, `cell_out` and `cfg_out` read 0.
- R2: Truth-table bits occupy chain positions 0 to 7. When bit 8 (bypass) is 1, `cell_out` equals truth bit number `lut_in`, with `lut_in` read as unsigned, within the same cycle. A table of 8'h80 gives the AND of the three inputs. A table of 8'hAB gives (~in2 & ~in1) | in0.
- R3: On each rising `cfg_clk` with `cfg_shift_en` high, every position takes the bit of the next higher position and position 11 takes `cfg_in`. `cfg_out` shows position 0. The first bit shifted in therefore lands in position 0 (truth bit 0), and the last lands in position 11. Bits leave on `cfg_out` in the order they arrived.
- R4: While `cfg_shift_en` is low, the configuration does not change, whatever `cfg_in` does.
- R5: When bit 8 is 0 and bit 11 (edge select) is 0, `cell_out` takes truth bit `lut_in` at each rising `clk` edge.
- R6: When bit 8 is 0 and bit 11 is 1, the register captures at the falling `clk` edge instead.
- R7: When bit 10 (reset enable) is 1, a high `rst_req` at the selected edge loads 0. When bit 10 is 0, `rst_req` has no effect.
- R8: When bit 9 (set enable) is 1, a high `set_req` at the selected edge loads 1. When bit 9 is 0, `set_req` has no effect.
- R9: When set and reset are both enabled and both requested, the register loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk | input | 1 | Configuration chain clock |
| cfg_shift_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration input |
| cfg_out | output | 1 | Serial configuration output to the next cell |
| lut_in | input | 3 | Lookup table select inputs |
| set_req | input | 1 | Synchronous set request |
| rst_req | input | 1 | Synchronous reset request |
| cell_out | output | 1 | Cell output, combinational or registered |

## Verification
A corrupted truth-table bit shows at `cell_out` only when `lut_in` addresses it. It appears at once in bypass mode, or one active edge later in registered mode. For that reason every configuration is swept over all eight input values. A wrong mode bit shows as output that changes on the wrong edge, or that ignores or obeys set and reset wrongly, and this appears within one clock. Chain faults appear on `cfg_out` during shift-out, in the order the bits are read back.

// File: rtl/cle_pkg.sv
`timescale 1ns/1ps
package cle_pkg;
    localparam int LUT_K    = 3;
    localparam int LUT_SIZE = 1 << LUT_K;
    localparam int CFG_W    = LUT_SIZE + 4;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    // Field order from bit 0 upward matches the shift order.
    typedef struct packed {
        edge_sel_e             clk_edge;
        logic                  rst_en;
        logic                  set_en;
        logic                  bypass;
        logic [LUT_SIZE-1:0]   truth;
    } cle_cfg_t;

    // Next state of the output register: reset wins over set.
    function automatic logic ff_next(input logic d,
                                     input logic set_req, input logic rst_req,
                                     input logic set_en,  input logic rst_en);
        if (rst_en && rst_req)      return 1'b0;
        else if (set_en && set_req) return 1'b1;
        else                        return d;
    endfunction
endpackage

// File: rtl/cle_cfg_chain.sv
`timescale 1ns/1ps
module cle_cfg_chain #(
    parameter int W = cle_pkg::CFG_W
) (
    input  logic         cfg_clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic         dout,
    output logic [W-1:0] word
);
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == W - 1) begin : g_head
            always_ff @(posedge cfg_clk) begin
                if (rst)           word[i] <= 1'b0;
                else if (shift_en) word[i] <= din;
            end
        end else begin : g_body
            always_ff @(posedge cfg_clk) begin
                if (rst)           word[i] <= 1'b0;
                else if (shift_en) word[i] <= word[i+1];
            end
        end
    end

    assign dout = word[0];
endmodule

// File: rtl/cle_lut.sv
`timescale 1ns/1ps
module cle_lut #(
    parameter int K = cle_pkg::LUT_K,
    localparam int N = 1 << K
) (
    input  logic [N-1:0] truth,
    input  logic [K-1:0] sel,
    output logic         y
);
    assign y = truth[sel];
endmodule

// File: rtl/cle_out_ff.sv
`timescale 1ns/1ps
module cle_out_ff #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic set_req,
    input  logic rst_req,
    input  logic set_en,
    input  logic rst_en,
    output logic q
);
    if (FALLING) begin : g_neg
        always_ff @(negedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= cle_pkg::ff_next(d, set_req, rst_req, set_en, rst_en);
        end
    end else begin : g_pos
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= cle_pkg::ff_next(d, set_req, rst_req, set_en, rst_en);
        end
    end
endmodule

// File: rtl/cle_cell.sv
`timescale 1ns/1ps
module cle_cell (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_clk,
    input  logic       cfg_shift_en,
    input  logic       cfg_in,
    output logic       cfg_out,
    input  logic [2:0] lut_in,
    input  logic       set_req,
    input  logic       rst_req,
    output logic       cell_out
);
    import cle_pkg::*;

    logic [CFG_W-1:0] cfg_word;
    cle_cfg_t         cfg_q;
    logic             lut_y;
    logic [1:0]       q_edge;

    cle_cfg_chain #(.W(CFG_W)) i_chain (
        .cfg_clk  (cfg_clk),
        .rst      (rst),
        .shift_en (cfg_shift_en),
        .din      (cfg_in),
        .dout     (cfg_out),
        .word     (cfg_word)
    );

    assign cfg_q = cle_cfg_t'(cfg_word);

    cle_lut #(.K(LUT_K)) i_lut (
        .truth (cfg_q.truth),
        .sel   (lut_in),
        .y     (lut_y)
    );

    // One register per edge; the edge bit picks which one is visible.
    for (genvar e = 0; e < 2; e++) begin : g_edge
        cle_out_ff #(.FALLING(e == 1)) i_ff (
            .clk     (clk),
            .rst     (rst),
            .d       (lut_y),
            .set_req (set_req),
            .rst_req (rst_req),
            .set_en  (cfg_q.set_en),
            .rst_en  (cfg_q.rst_en),
            .q       (q_edge[e])
        );
    end

    assign cell_out = cfg_q.bypass ? lut_y : q_edge[cfg_q.clk_edge];
endmodule

// File: rtl/cle_cell_chk.sv
`timescale 1ns/1ps
module cle_cell_chk (
    input logic              clk,
    input logic              rst,
    input logic              cfg_clk,
    input logic              cfg_shift_en,
    input logic              cfg_in,
    input logic [2:0]        lut_in,
    input logic              set_req,
    input logic              rst_req,
    input logic              cell_out,
    input cle_pkg::cle_cfg_t cfg
);
    import cle_pkg::*;

    logic [CFG_W-1:0] cw;
    logic             use_rise;
    logic             use_fall;
    logic             rst_hit;
    logic             set_hit;
    assign cw       = cfg;
    assign use_rise = !cfg.bypass && cfg.clk_edge == EDGE_RISE && !cfg_shift_en;
    assign use_fall = !cfg.bypass && cfg.clk_edge == EDGE_FALL && !cfg_shift_en;
    assign rst_hit  = cfg.rst_en && rst_req;
    assign set_hit  = cfg.set_en && set_req;

    assert_reset_clears_R1: assert property (@(posedge cfg_clk)
        rst |=> (cw == '0));

    assert_chain_entry_R3: assert property (@(posedge cfg_clk) disable iff (rst)
        cfg_shift_en |=> (cw[CFG_W-1] == $past(cfg_in)));

    assert_chain_hold_R4: assert property (@(posedge cfg_clk) disable iff (rst)
        !cfg_shift_en |=> $stable(cw));

    assert_comb_path_R2: assert property (@(posedge clk) disable iff (rst)
        cfg.bypass |-> (cell_out == cw[lut_in]));

    assert_rise_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (use_rise && !rst_hit && !set_hit) |=> (cell_out == $past(cw[lut_in])));

    assert_set_load_R8: assert property (@(posedge clk) disable iff (rst)
        (use_rise && set_hit && !rst_hit) |=> cell_out);

    assert_reset_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (use_rise && rst_hit) |=> !cell_out);

    assert_fall_capture_R6: assert property (@(negedge clk) disable iff (rst)
        (use_fall && !rst_hit && !set_hit) |=>
            (!$stable(cw) || cell_out == $past(cw[lut_in])));
endmodule

bind cle_cell cle_cell_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_clk      (cfg_clk),
    .cfg_shift_en (cfg_shift_en),
    .cfg_in       (cfg_in),
    .lut_in       (lut_in),
    .set_req      (set_req),
    .rst_req      (rst_req),
    .cell_out     (cell_out),
    .cfg          (cfg_q)
);

// File: tb/test_cle_cell.sv
`timescale 1ns/1ps
module test_cle_cell;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_clk;
    logic       cfg_shift_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic       cfg_out;
    logic [2:0] lut_in = '0;
    logic       set_req = 1'b0;
    logic       rst_req = 1'b0;
    logic       cell_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign cfg_clk = clk;

    cle_cell i_cle_cell (
        .clk(clk), .rst(rst), .cfg_clk(cfg_clk), .cfg_shift_en(cfg_shift_en),
        .cfg_in(cfg_in), .cfg_out(cfg_out), .lut_in(lut_in),
        .set_req(set_req), .rst_req(rst_req), .cell_out(cell_out)
    );

    function automatic logic [11:0] mk(input logic [7:0] h, input bit byp,
                                       input bit sen, input bit ren, input bit fall);
        return {fall, ren, sen, byp, h};
    endfunction

    function automatic bit exp_ff(input logic [11:0] w, input int idx,
                                  input bit s, input bit r);
        if (w[10] && r)      return 1'b0;
        else if (w[9] && s)  return 1'b1;
        else                 return w[idx];
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [11:0] w);
        for (int i = 0; i < 12; i++) begin
            cfg_in = w[i];
            cfg_shift_en = 1'b1;
            tick();
        end
        cfg_shift_en = 1'b0;
        cfg_in = 1'b0;
    endtask

    task automatic sweep_comb(input logic [11:0] w, input string tag);
        for (int i = 0; i < 8; i++) begin
            lut_in = 3'(i);
            #0.5;
            chk(cell_out, w[i], tag);
            tick();
        end
    endtask

    task automatic sweep_rise(input logic [11:0] w, input string tag);
        for (int i = 0; i < 8; i++) begin
            lut_in = 3'(i);
            tick();
            chk(cell_out, w[i], tag);
        end
    endtask

    task automatic sweep_fall(input logic [11:0] w, input string tag);
        for (int i = 0; i < 8; i++) begin
            lut_in = 3'(i);
            #2;
            chk(cell_out, w[i], tag);
            tick();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [11:0] w;
        void'($urandom(32'd20240611));
        tick(); tick();
        rst = 1'b0;
        #0.5;
        chk(cell_out, 1'b0, "R1 output after reset");
        chk(cfg_out, 1'b0, "R1 chain after reset");
        tick();

        // R2: AND and two-term functions, combinational
        w = mk(8'h80, 1, 0, 0, 0); load(w); sweep_comb(w, "R2 and comb");
        w = mk(8'hAB, 1, 0, 0, 0); load(w); sweep_comb(w, "R2 two-term comb");

        // R5: registered rising
        w = mk(8'h80, 0, 0, 0, 0); load(w); sweep_rise(w, "R5 and rise");
        w = mk(8'hAB, 0, 0, 0, 0); load(w); sweep_rise(w, "R5 two-term rise");

        // R6: registered falling
        w = mk(8'h80, 0, 0, 0, 1); load(w); sweep_fall(w, "R6 and fall");
        w = mk(8'hAB, 0, 0, 0, 1); load(w); sweep_fall(w, "R6 two-term fall");

        // R4: toggling cfg_in with shift disabled changes nothing
        w = mk(8'h5A, 1, 0, 0, 0); load(w);
        for (int i = 0; i < 10; i++) begin
            cfg_in = 1'($urandom);
            tick();
        end
        cfg_in = 1'b0;
        sweep_comb(w, "R4 hold");

        // R3: shift the word back out and compare order
        w = mk(8'hC6, 0, 1, 0, 1); load(w);
        for (int i = 0; i < 12; i++) begin
            chk(cfg_out, w[i], "R3 shift-out order");
            cfg_shift_en = 1'b1;
            tick();
        end
        cfg_shift_en = 1'b0;

        // R7: reset request with enable on and off, rising edge
        w = mk(8'hFF, 0, 0, 1, 0); load(w);
        rst_req = 1'b1; tick(); chk(cell_out, 1'b0, "R7 reset enabled");
        w = mk(8'hFF, 0, 0, 0, 0); load(w);
        rst_req = 1'b1; tick(); chk(cell_out, 1'b1, "R7 reset ignored");
        rst_req = 1'b0;

        // R8: set request with enable on and off
        w = mk(8'h00, 0, 1, 0, 0); load(w);
        set_req = 1'b1; tick(); chk(cell_out, 1'b1, "R8 set enabled");
        w = mk(8'h00, 0, 0, 0, 0); load(w);
        set_req = 1'b1; tick(); chk(cell_out, 1'b0, "R8 set ignored");

        // R9: both requested on both edges
        w = mk(8'hFF, 0, 1, 1, 0); load(w);
        set_req = 1'b1; rst_req = 1'b1; tick();
        chk(cell_out, 1'b0, "R9 priority rise");
        w = mk(8'hFF, 0, 1, 1, 1); load(w);
        set_req = 1'b1; rst_req = 1'b1; #2;
        chk(cell_out, 1'b0, "R9 priority fall");
        tick();
        set_req = 1'b0; rst_req = 1'b0;

        // Random configurations and stimulus
        for (int n = 0; n < 60; n++) begin
            w = 12'($urandom);
            load(w);
            for (int k = 0; k < 8; k++) begin
                int  idx;
                bit  s;
                bit  r;
                idx = int'($urandom_range(7, 0));
                s = 1'($urandom);
                r = 1'($urandom);
                lut_in = 3'(idx);
                set_req = s;
                rst_req = r;
                if (w[8]) begin
                    #0.5;
                    chk(cell_out, w[idx], "R2 random comb");
                    tick();
                end else if (!w[11]) begin
                    tick();
                    chk(cell_out, exp_ff(w, idx, s, r), "R5 R7 R8 R9 random rise");
                end else begin
                    #2;
                    chk(cell_out, exp_ff(w, idx, s, r), "R6 R7 R8 R9 random fall");
                    tick();
                end
            end
            set_req = 1'b0;
            rst_req = 1'b0;
        end

        // R1: reset in mid-operation clears configuration
        rst = 1'b1; tick(); rst = 1'b0;
        #0.5;
        chk(cell_out, 1'b0, "R1 output after late reset");
        for (int i = 0; i < 12; i++) begin
            chk(cfg_out, 1'b0, "R1 chain cleared");
            cfg_shift_en = 1'b1;
            tick();
        end
        cfg_shift_en = 1'b0;
        finish_run();
    end
endmodule